// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block sequences conversions for a multi-channel analog-to-digital converter. A static select input picks one of three trigger sources:
- a write strobe to a software trigger register,
- an active-low pulse on an external pin,
- a one-cycle tick from a periodic timer.

When a trigger is accepted, the block pulses a start line to the converter and counts a fixed conversion time. It then captures the 12-bit result and raises a ready flag. For the external and timer sources it also raises an interrupt.

Writing a new channel number opens a settling window. A trigger that arrives during that window is held back until the window closes. A trigger that arrives while a conversion is already running is dropped, and a sticky overrun flag records the loss. Software uses a four-word register interface: channel, trigger, status and data. Reading the data word clears the ready flag and the interrupt.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset the ready, busy, overrun and settling status bits are 0, the channel word reads 0, and both irq and conv_start are low.
- R2: Only the source chosen by trig_sel starts a conversion: 0 is the software trigger, 1 is the external pin, 2 is the timer tick and 3 selects none. Events from the other sources have no effect.
- R3: With trig_sel=0, a write to address 1 starts a conversion whatever data is written. conv_start is high for exactly the one cycle that follows the write edge.
- R4: ext_trig_n passes through a two-flop synchronizer. A falling edge makes conv_start rise after the third rising clock edge that samples the low level. Holding the pin low gives a single conversion, and a rising edge starts nothing.
- R5: A write to address 0 loads the channel and opens a window of SETTLE_CYC cycles. A trigger taken inside the window is held. conv_start then rises one cycle after the window ends, which is SETTLE_CYC+1 edges after the channel write edge.
- R6: CONV_CYC edges after conv_start rises, the ready bit is set and the conv_data value present at that edge is captured. The value is read at address 3 in the low 12 bits. conv_chan carries the current channel.
- R7: A read of address 3 clears the ready bit and irq.
- R8: irq is raised together with ready only for the external and timer sources. It is never raised for the software source.
- R9: A trigger from the selected source while a conversion is running starts nothing and sets the overrun bit. The overrun bit stays set until a read of address 2, which returns it set and then clears it.
- R10: The status word at address 2 holds ready in bit 0, busy in bit 1, overrun in bit 2 and settling in bit 3. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_sel | input | 2 | Static trigger source select (0 software, 1 external, 2 timer, 3 none) |
| ext_trig_n | input | 1 | Asynchronous external trigger, active low |
| timer_tick | input | 1 | One-cycle periodic trigger from a timer |
| reg_addr | input | 2 | Register address: 0 channel, 1 trigger, 2 status, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for read side effects) |
| reg_wdata | input | CH_W | Write data (channel number) |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | CH_W | Selected converter channel |
| conv_data | input | DATA_W | Converter result |
| irq | output | 1 | Result-ready interrupt for hardware sources |

## Verification
The results are due on these edges:
- A software write or a timer tick makes conv_start high on the edge that samples it.
- The external pin needs three edges, counted from the first edge that sees it low.
- ready, irq and the captured data appear CONV_CYC edges after conv_start rises.
- A trigger held by the settling window fires on edge SETTLE_CYC+1 after the channel write.

The bench drives inputs and samples outputs on the falling clock edge, and steps whole cycles from the edge that took each stimulus. Every check therefore lands on the exact cycle a result is due. In most cases it also looks one cycle earlier, to confirm that the result is not yet present.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    SRC_SOFT  = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_TIMER = 2'd2,
    SRC_NONE  = 2'd3
  } trig_src_e;

  localparam logic [1:0] ADDR_CHAN = 2'd0;
  localparam logic [1:0] ADDR_TRIG = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  localparam int RDATA_W = 16;
endpackage

// File: rtl/adc_ext_sync.sv
module adc_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_n,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], ext_n};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       soft_evt,
  input  logic       ext_evt,
  input  logic       tick_evt,
  output logic       trig_o
);
  always_comb begin
    case (trig_src_e'(sel))
      SRC_SOFT:  trig_o = soft_evt;
      SRC_EXT:   trig_o = ext_evt;
      SRC_TIMER: trig_o = tick_evt;
      default:   trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_dly_cnt.sv
module adc_dly_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int DATA_W      = 12,
  parameter int SETTLE_CYC  = 10000,
  parameter int CONV_CYC    = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         trig_sel,
  input  logic               ext_trig_n,
  input  logic               timer_tick,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [CH_W-1:0]    reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic               conv_start,
  output logic [CH_W-1:0]    conv_chan,
  input  logic [DATA_W-1:0]  conv_data,
  output logic               irq
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int CNV_W = $clog2(CONV_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  // decoded register strobes
  logic chan_wr, soft_evt, stat_rd, data_rd;
  assign chan_wr  = reg_wr && (reg_addr == ADDR_CHAN);
  assign soft_evt = reg_wr && (reg_addr == ADDR_TRIG);
  assign stat_rd  = reg_rd && (reg_addr == ADDR_STAT);
  assign data_rd  = reg_rd && (reg_addr == ADDR_DATA);

  // trigger sources
  logic ext_fall, trig_evt, soft_sel;

  adc_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (srst_n),
    .ext_n  (ext_trig_n),
    .fall_o (ext_fall)
  );

  adc_trig_sel u_sel (
    .sel      (trig_sel),
    .soft_evt (soft_evt),
    .ext_evt  (ext_fall),
    .tick_evt (timer_tick),
    .trig_o   (trig_evt)
  );

  assign soft_sel = (trig_sel == SRC_SOFT);

  // settling and conversion timers
  logic [SET_W-1:0] settle_cnt;
  logic [CNV_W-1:0] conv_cnt;
  logic             settle_active, busy, conv_done, start_go;

  adc_dly_cnt #(.W(SET_W)) u_settle (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (chan_wr),
    .load_val (SET_W'(SETTLE_CYC)),
    .cnt_o    (settle_cnt)
  );

  adc_dly_cnt #(.W(CNV_W)) u_conv (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (start_go),
    .load_val (CNV_W'(CONV_CYC)),
    .cnt_o    (conv_cnt)
  );

  assign settle_active = (settle_cnt != '0);
  assign busy          = (conv_cnt != '0);
  assign conv_done     = (conv_cnt == CNV_W'(1));

  // control state
  logic              pend_q, pend_d;
  logic              start_q;
  logic              ready_q, ready_d;
  logic              irq_q, irq_d;
  logic              ovr_q, ovr_d;
  logic [CH_W-1:0]   chan_q;
  logic [DATA_W-1:0] data_q;

  assign start_go = (trig_evt || pend_q) && !busy && !settle_active;

  always_comb begin
    // pending trigger: held only while the settling window runs
    if (pend_q)                                    pend_d = !start_go;
    else if (trig_evt && !busy && settle_active)   pend_d = 1'b1;
    else                                           pend_d = 1'b0;

    if (conv_done)     ready_d = 1'b1;
    else if (data_rd)  ready_d = 1'b0;
    else               ready_d = ready_q;

    if (conv_done)     irq_d = !soft_sel;
    else if (data_rd)  irq_d = 1'b0;
    else               irq_d = irq_q;

    if (trig_evt && busy) ovr_d = 1'b1;
    else if (stat_rd)     ovr_d = 1'b0;
    else                  ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      start_q <= start_go;
      ready_q <= ready_d;
      irq_q   <= irq_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      chan_q <= '0;
    else if (chan_wr) chan_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        data_q <= '0;
    else if (conv_done) data_q <= conv_data;
  end

  // read mux
  always_comb begin
    case (reg_addr)
      ADDR_CHAN: reg_rdata = RDATA_W'(chan_q);
      ADDR_STAT: reg_rdata = {12'd0, settle_active, ovr_q, busy, ready_q};
      ADDR_DATA: reg_rdata = RDATA_W'(data_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign irq        = irq_q;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic busy,
  input logic ready,
  input logic irq,
  input logic ovr,
  input logic settle,
  input logic data_rd,
  input logic stat_rd,
  input logic trig_evt,
  input logic conv_done,
  input logic soft_sel
);
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> !conv_start); // R9

  AST_NO_START_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    settle |=> !conv_start); // R5

  AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R6

  AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> ready); // R6

  AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !conv_done |=> !ready && !irq); // R7

  AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready); // R8

  AST_SOFT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    soft_sel && conv_done |=> !irq); // R8

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt && busy |=> ovr); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !stat_rd |=> ovr); // R9
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .conv_start (start_q),
  .busy       (busy),
  .ready      (ready_q),
  .irq        (irq_q),
  .ovr        (ovr_q),
  .settle     (settle_active),
  .data_rd    (data_rd),
  .stat_rd    (stat_rd),
  .trig_evt   (trig_evt),
  .conv_done  (conv_done),
  .soft_sel   (soft_sel)
);

// File: tb/adc_trig_ctrl_bench.sv
module adc_trig_ctrl_bench;
  localparam int CH_W = 3;
  localparam int DW   = 12;
  localparam int S    = 40;
  localparam int C    = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      trig_sel;
  logic            ext_trig_n;
  logic            timer_tick;
  logic [1:0]      reg_addr;
  logic            reg_wr;
  logic            reg_rd;
  logic [CH_W-1:0] reg_wdata;
  logic [15:0]     reg_rdata;
  logic            conv_start;
  logic [CH_W-1:0] conv_chan;
  logic [DW-1:0]   conv_data;
  logic            irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // converter stub: result depends on channel
  assign conv_data = 12'h300 + DW'(conv_chan) * 12'd17;

  adc_trig_ctrl #(.CH_W(CH_W), .DATA_W(DW), .SETTLE_CYC(S), .CONV_CYC(C)) u_adc_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .ext_trig_n(ext_trig_n),
    .timer_tick(timer_tick), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_data(conv_data), .irq(irq)
  );

  function automatic logic [15:0] exp_data(input int ch);
    return 16'(12'h300 + ch * 17);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CH_W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic set_chan(input logic [CH_W-1:0] ch);
    wr(2'd0, ch);
    step(S + 1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(2'd2, v);  chk("R1 status", v, 16'h0);
    peek(2'd0, v);  chk("R1 channel", v, 16'h0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 conv_start", conv_start, 1'b0);
  endtask

  task automatic t_soft();
    logic [15:0] v;
    trig_sel = 2'd0;
    wr(2'd0, 3'd2);
    peek(2'd2, v);  chk("R10 settle bit", v, 16'h8);
    step(S + 1);
    chk("R6 conv_chan", conv_chan, 3'd2);
    wr(2'd1, 3'd5);                      // data value irrelevant
    chk("R3 start after write", conv_start, 1'b1);
    peek(2'd2, v);  chk("R10 busy bit", v, 16'h2);
    step();
    chk("R3 start one cycle", conv_start, 1'b0);
    step(C - 2);
    peek(2'd2, v);  chk("R6 not ready early", v[0], 1'b0);
    step();
    peek(2'd2, v);  chk("R6 ready on time", v, 16'h1);
    chk("R8 no irq for software", irq, 1'b0);
    rd(2'd3, v);    chk("R6 data", v, exp_data(2));
    peek(2'd2, v);  chk("R7 ready cleared", v, 16'h0);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    trig_sel = 2'd0;
    timer_tick = 1'b1; step(); timer_tick = 1'b0;
    ext_trig_n = 1'b0; step(4); ext_trig_n = 1'b1;
    chk("R2 no start from others", conv_start, 1'b0);
    step(C + 4);
    peek(2'd2, v);  chk("R2 idle with other sources", v, 16'h0);
    trig_sel = 2'd3;
    wr(2'd1, 3'd0);
    step(C + 2);
    peek(2'd2, v);  chk("R2 none selected", v, 16'h0);
  endtask

  task automatic t_ext();
    logic [15:0] v;
    trig_sel = 2'd1;
    ext_trig_n = 1'b0;
    step(2);
    chk("R4 not yet started", conv_start, 1'b0);
    step();
    chk("R4 start after sync", conv_start, 1'b1);
    step(C - 1);
    peek(2'd2, v);  chk("R4 ready not early", v[0], 1'b0);
    chk("R8 irq not early", irq, 1'b0);
    step();
    peek(2'd2, v);  chk("R6 ready ext", v, 16'h1);
    chk("R8 irq ext", irq, 1'b1);
    ext_trig_n = 1'b1;
    step(6);
    peek(2'd2, v);  chk("R4 single conversion, rise ignored", v, 16'h1);
    rd(2'd3, v);    chk("R6 data ext", v, exp_data(2));
    chk("R7 irq cleared", irq, 1'b0);
  endtask

  task automatic t_timer();
    logic [15:0] v;
    trig_sel = 2'd2;
    set_chan(3'd6);
    timer_tick = 1'b1; step(); timer_tick = 1'b0;
    chk("R2 timer start", conv_start, 1'b1);
    step(C);
    chk("R8 irq timer", irq, 1'b1);
    rd(2'd3, v);    chk("R6 data timer", v, exp_data(6));
    chk("R7 irq cleared timer", irq, 1'b0);
    peek(2'd2, v);  chk("R7 ready cleared timer", v, 16'h0);
  endtask

  task automatic t_settle();
    logic [15:0] v;
    trig_sel = 2'd0;
    wr(2'd0, 3'd5);
    wr(2'd1, 3'd0);
    chk("R5 held while settling", conv_start, 1'b0);
    step(S - 1);
    chk("R5 not before window end", conv_start, 1'b0);
    peek(2'd2, v);  chk("R5 window over, idle", v, 16'h0);
    step();
    chk("R5 start after window", conv_start, 1'b1);
    step(C);
    rd(2'd3, v);    chk("R5 data after settle", v, exp_data(5));
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    trig_sel = 2'd0;
    wr(2'd1, 3'd0);
    step(3);
    wr(2'd1, 3'd0);
    chk("R9 no restart", conv_start, 1'b0);
    peek(2'd2, v);  chk("R9 overrun while busy", v, 16'h6);
    step(C - 4);
    peek(2'd2, v);  chk("R9 done with overrun", v, 16'h5);
    step(4);
    peek(2'd2, v);  chk("R9 second trigger dropped", v, 16'h5);
    rd(2'd2, v);    chk("R9 overrun read", v, 16'h5);
    peek(2'd2, v);  chk("R9 overrun cleared", v, 16'h1);
    rd(2'd3, v);    chk("R9 first result kept", v, exp_data(5));
  endtask

  initial begin
    rst_n = 1'b0; trig_sel = 2'd0; ext_trig_n = 1'b1; timer_tick = 1'b0;
    reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    step(4);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_soft();
    t_ignore();
    t_ext();
    t_timer();
    t_settle();
    t_overrun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule